// File: doc/BRIEF.md
# Coherent DMA Request Agent

This block is a small DMA agent attached to a cache-coherence fabric. A local sequencer hands it one job at a time: a read or a write, given as a byte address, a byte length and (for writes) a full line of data. The agent turns each job into a single request message for the home directory and drives it on the request channel with a valid/ready handshake. It then waits on an ordered response channel for the answer to that job.

A read is answered by a DATA response that always carries the whole line. The agent cuts out the bytes the job asked for, using the offset within the line and the length, and returns them to the sequencer with a one-cycle valid pulse. A write is answered by an ACK response, which the agent passes on as a one-cycle completion pulse. Responses are matched on the line address only. A response whose type is not the one the job expects, whose line differs from the job's, or that arrives when no job is waiting raises a one-cycle error pulse and is dropped. The job stays outstanding.

The controller has three states. `ST_READY` accepts a job (transition *accept*: job valid while ready). `ST_ISSUE` presents the request until it is taken (transition *sent*: request ready). `ST_AWAIT` waits for the matching response (transition *answered*: a matching response returns to `ST_READY`). A response that does not match leaves the controller in `ST_AWAIT`.

Top module: `dma_agent`

## Requirements
- R1: After reset `job_ready` is 1, and `req_valid`, `rd_valid`, `wr_done` and `err` are 0.
- R2: In the ready state a job is accepted on a cycle where `job_valid` and `job_ready` are both 1. From the next cycle until its response completes, `job_ready` is 0. A job held on `job_valid` during that time is not lost: it is accepted once the agent is ready again.
- R3: The cycle after acceptance, `req_valid` is 1. `req_type` is 2'b01 for a read job and 2'b10 for a write job. `req_addr`, `req_len` and `req_data` equal the job's address, length and data.
- R4: `req_dest` equals the line-number bits just above the line offset, `job_addr[OFF_W +: DEST_W]` (bits 4:3 with the defaults).
- R5: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and the whole request payload holds steady. On the cycle after `req_ready` is seen, `req_valid` is 0.
- R6: While a read job waits, a response with `rsp_type` 2'b01 (DATA) whose address matches the job's line completes the job. The low `OFF_W` address bits are ignored in the match. `rd_valid` is then 1 for one cycle on the following cycle, and `job_ready` returns to 1 in that same cycle.
- R7: When `rd_valid` is 1, byte i of `rd_data` (bits 8i+7:8i) is byte (offset+i) of the response line. This holds when i < length and offset+i < LINE_BYTES. Every other byte is 0.
- R8: While a write job waits, a matching response with `rsp_type` 2'b10 (ACK) completes the job. `wr_done` is 1 for one cycle on the following cycle.
- R9: On the cycle after `rsp_valid` is 1 and the response does not complete the job, `err` is 1 for one cycle. This covers type 2'b00 or 2'b11, DATA to a write, ACK to a read, a line mismatch, and no job waiting. In that case `rd_valid` and `wr_done` stay 0 and the agent's ready/waiting state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Sequencer offers a job |
| job_ready | output | 1 | Agent can take a job |
| job_write | input | 1 | 1 = write job, 0 = read job |
| job_addr | input | ADDR_W | Byte address of the job |
| job_len | input | LEN_W | Byte count of the job |
| job_data | input | LINE_BYTES*8 | Line of write data |
| req_valid | output | 1 | Request message present |
| req_ready | input | 1 | Fabric takes the request |
| req_type | output | 2 | Request message type |
| req_addr | output | ADDR_W | Full byte address |
| req_len | output | LEN_W | Byte count |
| req_data | output | LINE_BYTES*8 | Data line carried by the request |
| req_dest | output | DEST_W | Home directory index |
| rsp_valid | input | 1 | Response message present |
| rsp_type | input | 2 | Response message type |
| rsp_addr | input | ADDR_W | Response address |
| rsp_data | input | LINE_BYTES*8 | Full response line |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | LINE_BYTES*8 | Extracted read bytes |
| wr_done | output | 1 | Write completion pulse |
| err | output | 1 | Protocol error pulse |

## Verification
The bench uses response addresses whose offset bits differ from the job's. A design that compared full addresses would then flag errors instead of completing. Reads at offset 7 and with zero length stress the byte slice: an off-by-one shift or a mask that ignores the length would return stray bytes. A second job is held on the sequencer port during an outstanding one. A design that dropped it, or re-issued the first request, would show the wrong address or never answer. Wrong-kind, bad-type, wrong-line and unsolicited responses must each pulse the error without ending the job. A design that completed on any response would raise a done pulse early.

// File: rtl/dma_agent_pkg.sv
package dma_agent_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2
    } agent_state_e;

    localparam logic [1:0] MSG_DMA_RD = 2'b01;
    localparam logic [1:0] MSG_DMA_WR = 2'b10;
    localparam logic [1:0] RSP_DATA   = 2'b01;
    localparam logic [1:0] RSP_ACK    = 2'b10;

endpackage

// File: rtl/dma_agent_fsm.sv
module dma_agent_fsm
    import dma_agent_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic job_valid,
    input  logic req_ready,
    input  logic rsp_hit,
    output logic job_ready,
    output logic capture,
    output logic req_valid,
    output logic awaiting
);

    agent_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        job_ready = 1'b0;
        capture   = 1'b0;
        req_valid = 1'b0;
        awaiting  = 1'b0;
        unique case (state_q)
            ST_READY: begin
                job_ready = 1'b1;
                if (job_valid) begin
                    capture = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                req_valid = 1'b1;
                if (req_ready) state_d = ST_AWAIT;
            end
            ST_AWAIT: begin
                awaiting = 1'b1;
                if (rsp_hit) state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
    end

    assert_accept_issues_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid && job_ready) |=> (req_valid && !job_ready));

    assert_taken_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        job_ready |-> !req_valid && !awaiting);

endmodule

// File: rtl/dma_agent_slice.sv
module dma_agent_slice #(
    parameter int LINE_BYTES = 8,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int LEN_W      = $clog2(LINE_BYTES) + 1
) (
    input  logic [LINE_BYTES*8-1:0] line,
    input  logic [OFF_W-1:0]        offset,
    input  logic [LEN_W-1:0]        len,
    output logic [LINE_BYTES*8-1:0] bytes_out
);

    logic [LINE_BYTES*8-1:0] shifted;

    assign shifted = line >> {offset, 3'b000};

    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
        assign bytes_out[i*8 +: 8] = (LEN_W'(i) < len) ? shifted[i*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/dma_agent.sv
module dma_agent
    import dma_agent_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 8,
    parameter int DEST_W     = 2,
    parameter int LEN_W      = $clog2(LINE_BYTES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    job_valid,
    output logic                    job_ready,
    input  logic                    job_write,
    input  logic [ADDR_W-1:0]       job_addr,
    input  logic [LEN_W-1:0]        job_len,
    input  logic [LINE_BYTES*8-1:0] job_data,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [1:0]              req_type,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [LEN_W-1:0]        req_len,
    output logic [LINE_BYTES*8-1:0] req_data,
    output logic [DEST_W-1:0]       req_dest,
    input  logic                    rsp_valid,
    input  logic [1:0]              rsp_type,
    input  logic [ADDR_W-1:0]       rsp_addr,
    input  logic [LINE_BYTES*8-1:0] rsp_data,
    output logic                    rd_valid,
    output logic [LINE_BYTES*8-1:0] rd_data,
    output logic                    wr_done,
    output logic                    err
);

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'((1 << OFF_W) - 1);

    logic              capture, awaiting, rsp_hit, rsp_bad, kind_ok, line_ok;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LINE_W-1:0] data_q, sliced;

    dma_agent_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .job_valid (job_valid),
        .req_ready (req_ready),
        .rsp_hit   (rsp_hit),
        .job_ready (job_ready),
        .capture   (capture),
        .req_valid (req_valid),
        .awaiting  (awaiting)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
            data_q  <= '0;
        end else if (capture) begin
            write_q <= job_write;
            addr_q  <= job_addr;
            len_q   <= job_len;
            data_q  <= job_data;
        end
    end

    assign req_type = write_q ? MSG_DMA_WR : MSG_DMA_RD;
    assign req_addr = addr_q;
    assign req_len  = len_q;
    assign req_data = data_q;
    assign req_dest = addr_q[OFF_W +: DEST_W];

    assign line_ok = (rsp_addr & LINE_MASK) == (addr_q & LINE_MASK);
    assign kind_ok = write_q ? (rsp_type == RSP_ACK) : (rsp_type == RSP_DATA);
    assign rsp_hit = rsp_valid && awaiting && line_ok && kind_ok;
    assign rsp_bad = rsp_valid && !rsp_hit;

    dma_agent_slice #(
        .LINE_BYTES (LINE_BYTES),
        .OFF_W      (OFF_W),
        .LEN_W      (LEN_W)
    ) u_slice (
        .line      (rsp_data),
        .offset    (addr_q[OFF_W-1:0]),
        .len       (len_q),
        .bytes_out (sliced)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            wr_done  <= 1'b0;
            err      <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rsp_hit && !write_q;
            wr_done  <= rsp_hit && write_q;
            err      <= rsp_bad;
            if (rsp_hit && !write_q) rd_data <= sliced;
        end
    end

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_type)
                                       && $stable(req_len) && $stable(req_data)));

    assert_done_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_done, err}));

    assert_done_needs_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !awaiting) |=> (!rd_valid && !wr_done));

    assert_done_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_done) |-> job_ready);

    assert_err_holds_job_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && awaiting && !rsp_hit) |=> !job_ready);

endmodule

// File: tb/dma_agent_test.sv
module dma_agent_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LB = 8;
    localparam int LW = 4;
    localparam int NV = 6;
    localparam int VW = 1 + AW + LW + 64;

    // vector: {write, addr, len, response line}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 32'h0000_1000, 4'd8, 64'h8877_6655_4433_2211},
        {1'b0, 32'h0000_2013, 4'd2, 64'hF0E0_D0C0_B0A0_9080},
        {1'b1, 32'h0000_3015, 4'd3, 64'h0},
        {1'b0, 32'h0000_400F, 4'd1, 64'hABCD_EF01_2345_6789},
        {1'b0, 32'h0000_5002, 4'd0, 64'h1111_2222_3333_4444},
        {1'b0, 32'h0000_600E, 4'd4, 64'hDEAD_BEEF_CAFE_F00D}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic job_valid = 1'b0, job_write = 1'b0, req_ready = 1'b0, rsp_valid = 1'b0;
    logic [AW-1:0] job_addr = '0, rsp_addr = '0;
    logic [LW-1:0] job_len = '0;
    logic [63:0] job_data = '0, rsp_data = '0;
    logic [1:0] rsp_type = 2'b00;
    logic job_ready, req_valid, rd_valid, wr_done, err;
    logic [1:0] req_type, req_dest;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;
    logic [63:0] req_data, rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_agent uut (
        .clk(clk), .rst_n(rst_n),
        .job_valid(job_valid), .job_ready(job_ready), .job_write(job_write),
        .job_addr(job_addr), .job_len(job_len), .job_data(job_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_addr(req_addr), .req_len(req_len), .req_data(req_data), .req_dest(req_dest),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done), .err(err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] expect_slice(input logic [63:0] line,
                                                 input logic [2:0] off, input logic [3:0] len);
        logic [63:0] r = '0;
        for (int i = 0; i < LB; i++)
            if (i < int'(len) && int'(off) + i < LB)
                r[i*8 +: 8] = line[(int'(off) + i)*8 +: 8];
        return r;
    endfunction

    task automatic issue(input logic w, input logic [AW-1:0] a, input logic [LW-1:0] l,
                         input logic [63:0] d);
        @(negedge clk);
        job_valid = 1'b1; job_write = w; job_addr = a; job_len = l; job_data = d;
        @(negedge clk);
        job_valid = 1'b0;
    endtask

    task automatic take_req();
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic respond(input logic [1:0] t, input logic [AW-1:0] a, input logic [63:0] d);
        rsp_valid = 1'b1; rsp_type = t; rsp_addr = a; rsp_data = d;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 job_ready", 64'(job_ready), 64'd1);
        chk("R1 idle", 64'({req_valid, rd_valid, wr_done, err}), 64'd0);

        for (int v = 0; v < NV; v++) begin
            logic w;
            logic [AW-1:0] a;
            logic [LW-1:0] l;
            logic [63:0] line;
            {w, a, l, line} = VEC[v];
            issue(w, a, l, 64'hC0DE_0000_0000_0000 | 64'(v));
            chk("R3 req_valid", 64'(req_valid), 64'd1);
            chk("R3 req_type", 64'(req_type), w ? 64'd2 : 64'd1);
            chk("R3 req_addr", 64'(req_addr), 64'(a));
            chk("R3 req_len", 64'(req_len), 64'(l));
            chk("R3 req_data", req_data, 64'hC0DE_0000_0000_0000 | 64'(v));
            chk("R4 req_dest", 64'(req_dest), 64'(a[4:3]));
            take_req();
            chk("R5 req dropped", 64'(req_valid), 64'd0);
            chk("R2 busy", 64'(job_ready), 64'd0);
            // response offset bits differ from the job's (R6 line-only match)
            respond(w ? 2'b10 : 2'b01, a ^ 32'h7, line);
            if (w) chk("R8 wr_done", 64'({wr_done, rd_valid, err}), 64'b100);
            else begin
                chk("R6 rd_valid", 64'({rd_valid, wr_done, err}), 64'b100);
                chk("R7 rd_data", rd_data, expect_slice(line, a[2:0], l));
            end
            chk("R6 ready again", 64'(job_ready), 64'd1);
            @(negedge clk);
            chk("R6 one-cycle pulse", 64'({rd_valid, wr_done}), 64'd0);
        end

        // R5: request holds while not taken
        issue(1'b1, 32'h0000_7008, 4'd5, 64'h1234);
        repeat (3) @(negedge clk);
        chk("R5 held valid", 64'(req_valid), 64'd1);
        chk("R5 held addr", 64'(req_addr), 64'h7008);
        chk("R5 held len", 64'(req_len), 64'd5);
        take_req();

        // R9: wrong-kind, bad-type and wrong-line responses keep job pending
        respond(2'b01, 32'h0000_7008, 64'h0);
        chk("R9 data to write", 64'({err, wr_done, rd_valid}), 64'b100);
        chk("R9 still busy", 64'(job_ready), 64'd0);
        respond(2'b11, 32'h0000_7008, 64'h0);
        chk("R9 bad type", 64'({err, wr_done}), 64'b10);
        respond(2'b00, 32'h0000_7008, 64'h0);
        chk("R9 null type", 64'({err, wr_done}), 64'b10);
        respond(2'b10, 32'h0000_7010, 64'h0);
        chk("R9 wrong line", 64'({err, wr_done}), 64'b10);
        chk("R9 still busy 2", 64'(job_ready), 64'd0);
        respond(2'b10, 32'h0000_700F, 64'h0);
        chk("R8 ack after errors", 64'({wr_done, err}), 64'b10);

        // R9: unsolicited response while ready
        respond(2'b01, 32'h0000_1000, 64'h0);
        chk("R9 unsolicited err", 64'({err, rd_valid}), 64'b10);
        chk("R9 unsolicited ready", 64'(job_ready), 64'd1);

        // R9: ACK answering a read
        issue(1'b0, 32'h0000_8001, 4'd2, 64'h0);
        take_req();
        respond(2'b10, 32'h0000_8001, 64'h0);
        chk("R9 ack to read", 64'({err, wr_done, rd_valid}), 64'b100);
        respond(2'b01, 32'h0000_8000, 64'h0807_0605_0403_0201);
        chk("R7 slice after err", rd_data, 64'h0302);

        // R2: second job held during an outstanding one is accepted later
        issue(1'b0, 32'h0000_9000, 4'd8, 64'h0);
        job_valid = 1'b1; job_write = 1'b1; job_addr = 32'h0000_A018; job_len = 4'd1;
        repeat (2) @(negedge clk);
        chk("R2 hold off", 64'(job_ready), 64'd0);
        chk("R2 first kept", 64'(req_addr), 64'h9000);
        take_req();
        respond(2'b01, 32'h0000_9000, 64'h55);
        chk("R2 first done", 64'(rd_valid), 64'd1);
        @(negedge clk);
        job_valid = 1'b0;
        chk("R2 second issued", 64'(req_addr), 64'hA018);
        chk("R2 second type", 64'(req_type), 64'd2);
        chk("R4 second dest", 64'(req_dest), 64'd3);
        take_req();
        respond(2'b10, 32'h0000_A018, 64'h0);
        chk("R8 second ack", 64'(wr_done), 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule